// File: doc/BRIEF.md
# Tournament Predictor Chooser

This block sits between two component branch predictors and the fetch stage. Each lookup brings the two component predictions for one branch. The chooser returns the one that its per-branch selector currently trusts, together with a flag naming that component. Each selector is a 2-bit saturating counter with hysteresis. The selectors live in a table indexed by the low word-address bits of the branch PC, and the caller slices those bits off the PC.

When a branch resolves, the caller returns the two component predictions that were made for it, along with the real outcome. The selector moves toward the component that was right only when exactly one of them was right. It needs two such wins in a row against a strongly held preference before it switches. The component predictors themselves are outside this block.

Top module: `tourney_chooser`

## Requirements
- R1: After a synchronous reset every selector holds 01, weakly favouring predictor A, and `pred_valid` is low.
- R2: `pred_valid` is high in exactly the cycle after a cycle with `lookup_valid` high, and low in every other cycle.
- R3: Selector values 00 and 01 choose A (`pred_src`=0) and 10 and 11 choose B (`pred_src`=1). `pred_taken` equals the chosen component's prediction as registered at the lookup.
- R4: A resolve in which only B was correct raises the entry's selector by one, and the selector stays at 11 once it gets there.
- R5: A resolve in which only A was correct lowers the entry's selector by one, and the selector stays at 00 once it gets there.
- R6: A resolve in which both components were correct, or both were wrong, leaves the selector unchanged.
- R7: From 00, a single B-only win still chooses A, and a second B-only win in a row switches the choice to B. The same holds the other way round from 11.
- R8: A resolve changes only the entry at `resolve_idx`, and other entries keep their choice.
- R9: A lookup and a resolve on the same entry in the same cycle give the lookup the value from before the update, and a lookup in the next cycle sees the new value.
- R10: With `resolve_valid` low, the resolve inputs have no effect on any selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_idx | input | IDX_W | Table index taken from low word-address PC bits |
| lookup_pred_a | input | 1 | Component A prediction (1 = taken) |
| lookup_pred_b | input | 1 | Component B prediction (1 = taken) |
| resolve_valid | input | 1 | A resolved branch is presented this cycle |
| resolve_idx | input | IDX_W | Table index of the resolved branch |
| resolve_pred_a | input | 1 | Component A prediction that was made for the branch |
| resolve_pred_b | input | 1 | Component B prediction that was made for the branch |
| resolve_taken | input | 1 | Actual outcome (1 = taken) |
| pred_valid | output | 1 | Registered result is valid |
| pred_taken | output | 1 | Chosen prediction |
| pred_src | output | 1 | Component used: 0 = A, 1 = B |

## Verification
Each lookup result appears one clock edge after the lookup is presented. A resolve changes the selector at the same edge it is presented, so any lookup from the following cycle onward sees the new value, and a lookup in the same cycle sees the old one. The driver takes in its expected result only after the edge that captures the lookup. The monitor compares at the falling edge that follows, so every comparison lands on the cycle the result is due. The monitor also flags any cycle in which `pred_valid` disagrees with whether a result is pending.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        SEL_STRONG_A = 2'b00,
        SEL_WEAK_A   = 2'b01,
        SEL_WEAK_B   = 2'b10,
        SEL_STRONG_B = 2'b11
    } sel_t;

    localparam sel_t SEL_RESET = SEL_WEAK_A;

    typedef struct packed {
        logic a_hit;
        logic b_hit;
    } verdict_t;

    typedef struct packed {
        logic taken;
        logic use_b;
    } choice_t;

    function automatic logic sel_picks_b(sel_t s);
        return s[1];
    endfunction

    function automatic verdict_t judge(logic pa, logic pb, logic actual);
        verdict_t v;
        v.a_hit = (pa == actual);
        v.b_hit = (pb == actual);
        return v;
    endfunction

    function automatic sel_t sel_train(sel_t s, verdict_t v);
        sel_t n;
        n = s;
        if (v.b_hit && !v.a_hit) begin
            if (s != SEL_STRONG_B) n = sel_t'(s + 2'd1);
        end else if (v.a_hit && !v.b_hit) begin
            if (s != SEL_STRONG_A) n = sel_t'(s - 2'd1);
        end
        return n;
    endfunction

endpackage

// File: rtl/tc_sel_table.sv
module tc_sel_table
    import tc_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output sel_t             rd_sel,
    input  logic [IDX_W-1:0] up_idx,
    output sel_t             up_sel,
    input  logic             wr_en,
    input  sel_t             wr_sel
);

    sel_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= SEL_RESET;
        end else if (wr_en) begin
            mem[up_idx] <= wr_sel;
        end
    end

    assign rd_sel = mem[rd_idx];
    assign up_sel = mem[up_idx];

endmodule

// File: rtl/tc_trainer.sv
module tc_trainer
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic res_valid,
    input  logic res_pred_a,
    input  logic res_pred_b,
    input  logic res_taken,
    input  sel_t old_sel,
    output logic wr_en,
    output sel_t new_sel
);

    verdict_t vd;

    always_comb begin
        vd      = judge(res_pred_a, res_pred_b, res_taken);
        new_sel = sel_train(old_sel, vd);
        wr_en   = res_valid && (vd.a_hit != vd.b_hit);
    end

    AST_TIE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_pred_a == res_pred_b)) |-> (!wr_en || new_sel == old_sel)); // R6

    AST_B_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pred_b == res_taken && res_pred_a != res_taken)
        |-> (old_sel == SEL_STRONG_B) ? (new_sel == SEL_STRONG_B)
                                      : (2'(new_sel) == 2'(old_sel) + 2'd1)); // R4

    AST_A_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pred_a == res_taken && res_pred_b != res_taken)
        |-> (old_sel == SEL_STRONG_A) ? (new_sel == SEL_STRONG_A)
                                      : (2'(new_sel) + 2'd1 == 2'(old_sel))); // R5

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !wr_en); // R10

endmodule

// File: rtl/tc_pick.sv
module tc_pick
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lk_valid,
    input  logic lk_pred_a,
    input  logic lk_pred_b,
    input  sel_t lk_sel,
    output logic out_valid,
    output logic out_taken,
    output logic out_src
);

    choice_t ch_d, ch_q;
    logic    vld_q;

    always_comb begin
        ch_d.use_b = sel_picks_b(lk_sel);
        ch_d.taken = ch_d.use_b ? lk_pred_b : lk_pred_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ch_q  <= '0;
        end else begin
            vld_q <= lk_valid;
            if (lk_valid) ch_q <= ch_d;
        end
    end

    assign out_valid = vld_q;
    assign out_taken = ch_q.taken;
    assign out_src   = ch_q.use_b;

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(lk_valid))); // R2

    AST_PICK_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid)) |->
        (out_taken == (out_src ? $past(lk_pred_b) : $past(lk_pred_a)))); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R1

endmodule

// File: rtl/tourney_chooser.sv
module tourney_chooser
    import tc_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lookup_valid,
    input  logic [IDX_W-1:0] lookup_idx,
    input  logic             lookup_pred_a,
    input  logic             lookup_pred_b,
    input  logic             resolve_valid,
    input  logic [IDX_W-1:0] resolve_idx,
    input  logic             resolve_pred_a,
    input  logic             resolve_pred_b,
    input  logic             resolve_taken,
    output logic             pred_valid,
    output logic             pred_taken,
    output logic             pred_src
);

    sel_t lk_sel, up_old, up_new;
    logic up_wr;

    tc_sel_table #(.DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (lookup_idx),
        .rd_sel (lk_sel),
        .up_idx (resolve_idx),
        .up_sel (up_old),
        .wr_en  (up_wr),
        .wr_sel (up_new)
    );

    tc_trainer u_trainer (
        .clk        (clk),
        .rst        (rst),
        .res_valid  (resolve_valid),
        .res_pred_a (resolve_pred_a),
        .res_pred_b (resolve_pred_b),
        .res_taken  (resolve_taken),
        .old_sel    (up_old),
        .wr_en      (up_wr),
        .new_sel    (up_new)
    );

    tc_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lookup_valid),
        .lk_pred_a (lookup_pred_a),
        .lk_pred_b (lookup_pred_b),
        .lk_sel    (lk_sel),
        .out_valid (pred_valid),
        .out_taken (pred_taken),
        .out_src   (pred_src)
    );

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_wr) && !(resolve_valid && resolve_idx == $past(resolve_idx)))
        |-> (resolve_idx != $past(resolve_idx)) || (up_old == $past(up_new))); // R8

endmodule

// File: tb/tourney_chooser_tb.sv
`timescale 1ns/1ps
module tourney_chooser_tb;

    localparam int DEPTH = 1024;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lookup_valid = 1'b0;
    logic [IDX_W-1:0] lookup_idx = '0;
    logic lookup_pred_a = 1'b0, lookup_pred_b = 1'b0;
    logic resolve_valid = 1'b0;
    logic [IDX_W-1:0] resolve_idx = '0;
    logic resolve_pred_a = 1'b0, resolve_pred_b = 1'b0, resolve_taken = 1'b0;
    logic pred_valid, pred_taken, pred_src;

    always #2.5 clk = ~clk;

    tourney_chooser #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .lookup_valid(lookup_valid), .lookup_idx(lookup_idx),
        .lookup_pred_a(lookup_pred_a), .lookup_pred_b(lookup_pred_b),
        .resolve_valid(resolve_valid), .resolve_idx(resolve_idx),
        .resolve_pred_a(resolve_pred_a), .resolve_pred_b(resolve_pred_b),
        .resolve_taken(resolve_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_src(pred_src)
    );

    typedef struct {
        logic  taken;
        logic  src;
        string req;
    } exp_t;

    exp_t exp_q[$];
    logic [1:0] mdl [DEPTH];
    int tests = 0;
    int fails = 0;
    bit done = 0;

    // One cycle: optional lookup and optional resolve, presented together.
    task automatic step(input bit lv, input int li, input bit pa, input bit pb,
                        input bit rv, input int ri, input bit ra, input bit rb,
                        input bit rt, input string req);
        exp_t e;
        bit   push;
        @(negedge clk);
        lookup_valid  = lv; lookup_idx = IDX_W'(li);
        lookup_pred_a = pa; lookup_pred_b = pb;
        resolve_valid = rv; resolve_idx = IDX_W'(ri);
        resolve_pred_a = ra; resolve_pred_b = rb; resolve_taken = rt;
        push  = lv;
        e.src   = mdl[li][1];
        e.taken = e.src ? pb : pa;
        e.req   = req;
        if (rv) begin
            if ((rb == rt) && (ra != rt) && mdl[ri] != 2'b11) mdl[ri] = mdl[ri] + 2'd1;
            else if ((ra == rt) && (rb != rt) && mdl[ri] != 2'b00) mdl[ri] = mdl[ri] - 2'd1;
        end
        @(posedge clk);
        if (push) exp_q.push_back(e);
    endtask

    task automatic look(input int idx, input bit pa, input bit pb, input string req);
        step(1, idx, pa, pb, 0, 0, 0, 0, 0, req);
    endtask

    // kind: 1 = only B right, 2 = only A right, 3 = both right, 4 = both wrong
    task automatic train(input int idx, input int kind, input bit valid);
        case (kind)
            1: step(0, 0, 0, 0, valid, idx, 0, 1, 1, "");
            2: step(0, 0, 0, 0, valid, idx, 1, 0, 1, "");
            3: step(0, 0, 0, 0, valid, idx, 1, 1, 1, "");
            default: step(0, 0, 0, 0, valid, idx, 0, 0, 1, "");
        endcase
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: results are due one edge after the lookup; compare at the falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (pred_valid != (exp_q.size() > 0)) begin
                tests++; fails++;
                $display("FAIL R2 pred_valid=%0d expected=%0d", pred_valid, exp_q.size() > 0);
            end
            if (pred_valid && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                tests++;
                if (pred_taken !== e.taken || pred_src !== e.src) begin
                    fails++;
                    $display("FAIL %s taken/src=%0d/%0d expected=%0d/%0d",
                             e.req, pred_taken, pred_src, e.taken, e.src);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (pred_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 pred_valid during reset=%0d expected=0", pred_valid);
        end
        rst = 1'b0;

        // R1: fresh entries choose A
        look(0, 1, 0, "R1");
        look(DEPTH-1, 0, 1, "R1");
        look(77, 1, 1, "R1");
        idle();

        // R4 / R3: B wins, saturate at 11, one A win keeps B
        train(16, 1, 1);
        look(16, 0, 1, "R3");
        look(16, 1, 0, "R3");
        train(16, 1, 1);
        train(16, 1, 1);
        train(16, 1, 1);
        train(16, 2, 1);
        look(16, 1, 0, "R4");

        // R5 / R7: A wins saturate at 00, then two B wins needed
        train(32, 2, 1);
        train(32, 2, 1);
        train(32, 2, 1);
        train(32, 1, 1);
        look(32, 1, 0, "R5");
        train(32, 1, 1);
        look(32, 1, 0, "R7");
        train(32, 1, 1);
        look(32, 0, 1, "R7");
        train(32, 1, 1);
        train(32, 2, 1);
        look(32, 0, 1, "R7");
        train(32, 2, 1);
        look(32, 1, 0, "R7");

        // R6: ties leave the selector alone
        train(48, 1, 1);
        train(48, 3, 1);
        train(48, 4, 1);
        train(48, 3, 1);
        look(48, 1, 0, "R6");
        train(48, 2, 1);
        look(48, 0, 1, "R6");

        // R10: resolve fields ignored without resolve_valid
        train(64, 1, 0);
        train(64, 1, 0);
        look(64, 1, 0, "R10");

        // R8: neighbours untouched
        train(80, 1, 1);
        train(80, 1, 1);
        look(79, 1, 0, "R8");
        look(81, 1, 0, "R8");
        look(80, 1, 0, "R8");

        // R9: same-cycle lookup and resolve on one entry
        step(1, 96, 1, 0, 1, 96, 0, 1, 1, "R9");
        look(96, 1, 0, "R9");
        step(1, 96, 0, 1, 1, 96, 1, 0, 1, "R9");
        look(96, 0, 1, "R9");

        // R2 / R3: back-to-back lookups with mixed patterns
        look(16, 0, 0, "R3");
        look(32, 1, 1, "R3");
        look(0, 0, 1, "R2");
        idle();
        idle();
        look(48, 1, 1, "R2");
        idle();
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule